// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Protection Controller

This block guards the half bridges of a PWM power stage against overcurrent. Each half bridge has its own protection slice. The slice receives the high-side PWM command and a digitized comparator flag that reports when the output current is above the limit. It drives a high-side gate enable, a low-side gate enable and a high-impedance shutdown flag. A frame strobe shared by all slices marks the start of each PWM period.

In cycle-by-cycle mode, a rising PWM edge arms a current-limit latch that turns the high side on. A qualified overcurrent event clears that latch, which flips the bridge to its low side for the rest of the frame. A leaky per-channel overload counter rises for each frame that had an event and falls for each clean frame. Short transients therefore pass, but a sustained fault drives the channel into high impedance. In latched mode the first event shuts the channel down at once.

A shut-down channel stays off until a synchronous reset request. A small decoder maps an external threshold code to a comparator level. Any code outside the valid range selects the lowest level.

Top module: `ocp_ctrl`

## Requirements
- R1: After rst_n low or a one-cycle reset_req, every channel shows hiz=0, hs_en=0, ls_en=1, and its overload counter is zero.
- R2: A rising edge of pwm_hs (high now, low in the previous cycle) sets the channel's limit latch. From the next cycle hs_en=1 and ls_en=0. A low pwm_hs clears the latch, giving hs_en=0 and ls_en=1 from the next cycle.
- R3: oc_flag high while the latch is set and the channel is not shut down is an overcurrent event. In the next cycle the latch is clear, with hs_en=0 and ls_en=1 (cycle-by-cycle mode).
- R4: After an event, further pwm_hs rising edges leave hs_en low until a frame_start cycle. A rising edge in the frame_start cycle sets the latch again.
- R5: In each frame_start cycle the overload counter moves up by one if the ending frame had at least one event, and otherwise down by one, holding at zero. Any number of oc_flag assertions within one frame counts as one.
- R6: When a frame_start update brings the counter to CNT_MAX (default 4), hiz=1 with hs_en=0 and ls_en=0 from the next cycle.
- R7: A channel with hiz=1 keeps hiz=1, hs_en=0 and ls_en=0 whatever pwm_hs, oc_flag and frame_start do, until reset_req or rst_n.
- R8: With mode_latched=1, an event sets hiz=1 in the next cycle.
- R9: oc_flag while the limit latch is clear is ignored: it neither truncates a later pulse nor adds to the counter.
- R10: Each channel's latch, counter and shutdown act only on that channel's own pwm_hs and oc_flag bits (bit i is channel i).
- R11: thr_sel equals thr_code when thr_code < THR_LEVELS (default 4) and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of each PWM frame |
| pwm_hs | input | NCH | High-side PWM command, one bit per channel |
| oc_flag | input | NCH | Digitized overcurrent comparator output per channel |
| mode_latched | input | 1 | 1 = shut down on first event, 0 = cycle-by-cycle |
| reset_req | input | 1 | Synchronous clear of all latches, counters and shutdowns |
| thr_code | input | CODE_W | Requested threshold code |
| thr_sel | output | SEL_W | Threshold level sent to the comparator |
| hs_en | output | NCH | High-side gate enable per channel |
| ls_en | output | NCH | Low-side gate enable per channel |
| hiz | output | NCH | Channel shut down to high impedance |

## Verification
The hardest state to reach from the ports is the exact value of the overload counter, because it is never brought out. The only thing that shows it is the frame in which hiz appears. The stimulus therefore runs sequences of hit and clean frames whose shutdown frame differs under a wrong count. One sequence runs clean frames first, so a counter that wraps below zero would shut down early. Another interleaves a clean frame among hits, so a counter that never leaks would shut down early. A third holds oc_flag for several cycles per frame, so a counter that counts each assertion would shut down early.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    DRV_LOW  = 2'd0,
    DRV_HIGH = 2'd1,
    DRV_OFF  = 2'd2
  } drv_e;

  // leaky overload step: up on a hit frame, down on a clean one
  function automatic int unsigned ovl_step(input int unsigned cur,
                                           input logic hit,
                                           input int unsigned lim);
    if (hit) return (cur >= lim) ? lim : cur + 1;
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // out-of-range threshold codes fall back to the lowest level
  function automatic int unsigned thr_map(input int unsigned code,
                                          input int unsigned levels);
    return (code < levels) ? code : 0;
  endfunction

endpackage

// File: rtl/ocp_thr_decode.sv
module ocp_thr_decode #(
  parameter int CODE_W     = 3,
  parameter int THR_LEVELS = 4,
  localparam int SEL_W     = (THR_LEVELS > 1) ? $clog2(THR_LEVELS) : 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [SEL_W-1:0]  sel
);
  always_comb begin
    sel = SEL_W'(ocp_pkg::thr_map(32'(code), THR_LEVELS));
  end

  always_comb begin
    assert_thr_range_R11: assert (32'(sel) < THR_LEVELS);
  end
endmodule

// File: rtl/ocp_ovl_counter.sv
module ocp_ovl_counter #(
  parameter int CNT_W   = 4,
  parameter int CNT_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic hit,
  input  logic freeze,
  output logic full
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = CNT_W'(ocp_pkg::ovl_step(32'(cnt_q), hit, CNT_MAX));
    full   = tick && !freeze && (32'(cnt_nx) == CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)        cnt_q <= '0;
    else if (tick && !freeze) cnt_q <= cnt_nx;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= CNT_MAX);
  assert_cnt_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/ocp_channel.sv
module ocp_channel #(
  parameter int CNT_W   = 4,
  parameter int CNT_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic frame_start,
  input  logic pwm_in,
  input  logic oc_in,
  input  logic mode_latched,
  output logic hs_en,
  output logic ls_en,
  output logic hiz
);
  import ocp_pkg::*;

  logic pwm_q, latch_q, trip_q, hit_q, hiz_q;
  logic rise, oc_evt, blocked, full, shut;
  drv_e drv;

  assign rise    = pwm_in && !pwm_q;
  assign oc_evt  = oc_in && latch_q && !hiz_q;
  assign blocked = trip_q && !frame_start;
  assign shut    = (mode_latched && oc_evt) || full;

  ocp_ovl_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .tick   (frame_start),
    .hit    (hit_q),
    .freeze (hiz_q),
    .full   (full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      latch_q <= 1'b0;
      trip_q  <= 1'b0;
      hit_q   <= 1'b0;
      hiz_q   <= 1'b0;
    end else begin
      pwm_q <= pwm_in;
      if (clr) begin
        latch_q <= 1'b0;
        trip_q  <= 1'b0;
        hit_q   <= 1'b0;
        hiz_q   <= 1'b0;
      end else begin
        hiz_q <= hiz_q || shut;
        hit_q <= frame_start ? oc_evt : (hit_q || oc_evt);
        if (oc_evt)           trip_q <= 1'b1;
        else if (frame_start) trip_q <= 1'b0;
        if (hiz_q || shut || oc_evt) latch_q <= 1'b0;
        else if (rise && !blocked)   latch_q <= 1'b1;
        else if (!pwm_in)            latch_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (hiz_q)        drv = DRV_OFF;
    else if (latch_q) drv = DRV_HIGH;
    else              drv = DRV_LOW;
    hs_en = (drv == DRV_HIGH);
    ls_en = (drv == DRV_LOW);
    hiz   = hiz_q;
  end

  assert_trip_cuts_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_evt && !clr) |=> (!hs_en && (ls_en || hiz)));
  assert_trip_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !frame_start && !clr) |=> !hs_en);
  assert_full_shuts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> hiz);
  assert_hiz_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_q && !clr) |=> (hiz_q && !hs_en && !ls_en));
  assert_latched_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_latched && oc_evt && !clr) |=> hiz);
endmodule

// File: rtl/ocp_ctrl.sv
module ocp_ctrl #(
  parameter int NCH        = 2,
  parameter int CNT_W      = 4,
  parameter int CNT_MAX    = 4,
  parameter int CODE_W     = 3,
  parameter int THR_LEVELS = 4,
  localparam int SEL_W     = (THR_LEVELS > 1) ? $clog2(THR_LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NCH-1:0]    pwm_hs,
  input  logic [NCH-1:0]    oc_flag,
  input  logic              mode_latched,
  input  logic              reset_req,
  input  logic [CODE_W-1:0] thr_code,
  output logic [SEL_W-1:0]  thr_sel,
  output logic [NCH-1:0]    hs_en,
  output logic [NCH-1:0]    ls_en,
  output logic [NCH-1:0]    hiz
);
  initial begin
    assert_cnt_fits: assert (CNT_MAX > 0 && CNT_MAX < (1 << CNT_W));
  end

  ocp_thr_decode #(.CODE_W(CODE_W), .THR_LEVELS(THR_LEVELS)) u_thr (
    .code (thr_code),
    .sel  (thr_sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ocp_channel #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (reset_req),
      .frame_start  (frame_start),
      .pwm_in       (pwm_hs[i]),
      .oc_in        (oc_flag[i]),
      .mode_latched (mode_latched),
      .hs_en        (hs_en[i]),
      .ls_en        (ls_en[i]),
      .hiz          (hiz[i])
    );
  end

  assert_clear_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (hiz == '0 && hs_en == '0));
endmodule

// File: tb/sim_ocp_ctrl.sv
`timescale 1ns/1ps
module sim_ocp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic [1:0] pwm_hs = '0, oc_flag = '0;
  logic       mode_latched = 1'b0, reset_req = 1'b0;
  logic [2:0] thr_code = '0;
  logic [1:0] thr_sel, hs_en, ls_en, hiz;

  int vectors = 0, miscompares = 0;
  logic hs0_l[8], ls0_l[8], hz0_l[8], hs1_l[8], hz1_l[8];

  always #2.5 clk = ~clk;

  ocp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pwm_hs(pwm_hs),
    .oc_flag(oc_flag), .mode_latched(mode_latched), .reset_req(reset_req),
    .thr_code(thr_code), .thr_sel(thr_sel), .hs_en(hs_en), .ls_en(ls_en), .hiz(hiz)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one 8-cycle PWM frame; bit k of each pattern applies in cycle k
  task automatic frame(input logic [7:0] pwm0, input logic [7:0] oc0, input logic [7:0] oc1);
    for (int k = 0; k < 8; k++) begin
      frame_start = (k == 0);
      pwm_hs  = {pwm0[k] & 1'b0 | (k < 4), pwm0[k]};
      oc_flag = {oc1[k], oc0[k]};
      @(posedge clk); #1;
      hs0_l[k] = hs_en[0]; ls0_l[k] = ls_en[0]; hz0_l[k] = hiz[0];
      hs1_l[k] = hs_en[1]; hz1_l[k] = hiz[1];
    end
    frame_start = 1'b0; pwm_hs = '0; oc_flag = '0;
  endtask

  task automatic pulse_clear();
    reset_req = 1'b1;
    @(posedge clk); #1;
    reset_req = 1'b0;
    check("R1 hiz after reset_req", int'(hiz), 0);
    check("R1 ls_en after reset_req", int'(ls_en), 3);
  endtask

  task automatic t_reset();
    check("R1 hiz after rst_n", int'(hiz), 0);
    check("R1 hs_en after rst_n", int'(hs_en), 0);
    check("R1 ls_en after rst_n", int'(ls_en), 3);
  endtask

  task automatic t_normal();
    frame(8'h0F, 8'h00, 8'h00);
    check("R2 hs on after rise", int'(hs0_l[0]), 1);
    check("R2 ls off while high", int'(ls0_l[2]), 0);
    check("R2 hs off after fall", int'(hs0_l[4]), 0);
    check("R2 ls on after fall", int'(ls0_l[4]), 1);
  endtask

  task automatic t_trip();
    pulse_clear();
    frame(8'h0F, 8'h02, 8'h00);
    check("R3 hs before event", int'(hs0_l[0]), 1);
    check("R3 hs cut by event", int'(hs0_l[1]), 0);
    check("R3 ls on after event", int'(ls0_l[1]), 1);
    check("R10 other channel unaffected", int'(hs1_l[1]), 1);
    frame(8'h0B, 8'h02, 8'h00);
    check("R4 rise after trip blocked", int'(hs0_l[3]), 0);
    frame(8'h0F, 8'h00, 8'h00);
    check("R4 new frame re-arms", int'(hs0_l[0]), 1);
  endtask

  task automatic t_leak();
    pulse_clear();
    // oc held three cycles per hit frame: must count once
    frame(8'h0F, 8'h0E, 8'h00);
    frame(8'h0F, 8'h0E, 8'h00);
    frame(8'h0F, 8'h0E, 8'h00);
    frame(8'h0F, 8'h00, 8'h00);
    check("R5 three hit frames no shutdown", int'(hz0_l[0]), 0);
    frame(8'h0F, 8'h02, 8'h00);
    frame(8'h0F, 8'h02, 8'h00);
    check("R5 leak kept count below max", int'(hz0_l[0]), 0);
    frame(8'h0F, 8'h00, 8'h00);
    check("R6 shutdown at max", int'(hz0_l[0]), 1);
    check("R6 hs off in shutdown", int'(hs0_l[0]), 0);
    check("R6 ls off in shutdown", int'(ls0_l[0]), 0);
    check("R10 other channel not shut", int'(hz1_l[7]), 0);
    frame(8'h0F, 8'h0E, 8'h00);
    check("R7 hiz held", int'(hz0_l[7]), 1);
    check("R7 hs held off", int'(hs0_l[0]), 0);
    check("R7 ls held off", int'(ls0_l[3]), 0);
    pulse_clear();
    check("R7 reset_req releases", int'(hiz[0]), 0);
  endtask

  task automatic t_saturate();
    pulse_clear();
    frame(8'h0F, 8'h00, 8'h00);
    frame(8'h0F, 8'h00, 8'h00);
    frame(8'h0F, 8'h02, 8'h00);
    frame(8'h0F, 8'h02, 8'h00);
    frame(8'h0F, 8'h02, 8'h00);
    frame(8'h0F, 8'h02, 8'h00);
    check("R5 zero floor holds", int'(hz0_l[0]), 0);
    frame(8'h0F, 8'h00, 8'h00);
    check("R6 fourth hit shuts down", int'(hz0_l[0]), 1);
  endtask

  task automatic t_ignore_low();
    pulse_clear();
    for (int f = 0; f < 5; f++) frame(8'h0F, 8'hE0, 8'h00);
    check("R9 no shutdown from low-side oc", int'(hz0_l[7]), 0);
    check("R9 pulse not truncated", int'(hs0_l[3]), 1);
  endtask

  task automatic t_latched();
    pulse_clear();
    mode_latched = 1'b1;
    frame(8'h0F, 8'h02, 8'h00);
    check("R8 first event shuts down", int'(hz0_l[1]), 1);
    check("R8 hs off", int'(hs0_l[1]), 0);
    check("R10 other channel running", int'(hz1_l[1]), 0);
    mode_latched = 1'b0;
    pulse_clear();
  endtask

  task automatic t_thr();
    for (int c = 0; c < 8; c++) begin
      thr_code = 3'(c);
      #1;
      check("R11 threshold decode", int'(thr_sel), (c < 4) ? c : 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_normal();
    t_trip();
    t_leak();
    t_saturate();
    t_ignore_low();
    t_latched();
    t_thr();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule